// File: doc/BRIEF.md
# Banked Access Conflict Gate

This block guards a storage array that is divided into several independently timed banks. A requester presents one index per clock. The block works out which bank that index falls in. In the same clock it answers whether the access may begin now, or must be retried because the bank is still serving an earlier access. Each granted access holds its bank for a fixed number of access cycles. During that time, any other index that lands in the same bank is turned away. Banks that hold no reservation answer independently of the others.

Time is kept in access cycles. Each access cycle spans a parameterised number of clocks. Because of this, a requester can repeat a request within the access cycle that opened a reservation. Such a repeat of the same index is granted again, and it leaves the reservation exactly as it was. If the latency is set to zero, the block holds no state and grants every request.

Top module: `banked_access_gate`

## Requirements
- R1: With LATENCY of zero, every valid request is granted and deny stays low.
- R2: The bank of a request is its index modulo NUM_BANKS (the low log2(NUM_BANKS) index bits).
- R3: A request is denied while its bank is reserved, unless R4 applies.
- R4: A request to a reserved bank is granted only if that reservation was opened in the current access cycle for the same index. Such a grant does not change the reservation. The same index in a later access cycle is denied.
- R5: A new grant in access cycle t reserves its bank through access cycle t+LATENCY-1. A request in cycle t+LATENCY is granted.
- R6: Reservations in one bank never deny requests to another bank.
- R7: With NUM_BANKS of one, every index shares the single bank.
- R8: After reset every bank is idle, so the first request is granted.
- R9: Without req_valid, grant and deny are both low. With req_valid, exactly one of them is high, combinationally in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this clock |
| req_index | input | IDX_W | Index of the requested access |
| grant | output | 1 | Request may start now |
| deny | output | 1 | Request refused; bank busy |

## Verification
The bench builds three copies side by side on the same request stream. The first has four banks, a latency of three and two clocks per access cycle. This is the only setting where a same-index repeat can fall into the opening access cycle, and where bank conflicts, expiry and cross-bank independence all occur together. The second has one bank, a latency of two and one clock per access cycle, so every index collides. The third has a latency of zero, which exercises the stateless pass-through.

// File: rtl/banked_access_gate.sv
module banked_access_gate #(
  parameter int NUM_BANKS   = 4,
  parameter int IDX_W       = 8,
  parameter int LATENCY     = 3,
  parameter int CLK_PER_CYC = 2,
  parameter int CYC_W       = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_index,
  output logic             grant,
  output logic             deny
);

  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int DIV_W  = (CLK_PER_CYC > 1) ? $clog2(CLK_PER_CYC) : 1;

  assign deny = req_valid && !grant;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!grant && !deny)); // R9
  AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (grant != deny)); // R9

  if (LATENCY == 0) begin : g_bypass
    assign grant = req_valid;

    AST_ZERO_LAT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> grant); // R1
  end else begin : g_track
    logic [CYC_W-1:0]  cyc;
    logic [DIV_W-1:0]  div;
    logic [BANK_W-1:0] bank_sel;
    logic [IDX_W-1:0]  e_idx   [NUM_BANKS];
    logic [CYC_W-1:0]  e_start [NUM_BANKS];
    logic [CYC_W-1:0]  e_end   [NUM_BANKS];
    logic              busy, same_open, new_res;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cyc <= CYC_W'(1);
        div <= '0;
      end else if (div == DIV_W'(CLK_PER_CYC - 1)) begin
        div <= '0;
        cyc <= cyc + CYC_W'(1);
      end else begin
        div <= div + DIV_W'(1);
      end
    end

    if (NUM_BANKS == 1) begin : g_one
      assign bank_sel = '0;
    end else begin : g_many
      assign bank_sel = req_index[BANK_W-1:0];
    end

    assign busy      = e_end[bank_sel] >= cyc;
    assign same_open = (e_start[bank_sel] == cyc) && (e_idx[bank_sel] == req_index);
    assign grant     = req_valid && (!busy || same_open);
    assign new_res   = req_valid && !busy;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          e_idx[b]   <= '0;
          e_start[b] <= '0;
          e_end[b]   <= '0;
        end else if (new_res && bank_sel == BANK_W'(b)) begin
          e_idx[b]   <= req_index;
          e_start[b] <= cyc;
          e_end[b]   <= cyc + CYC_W'(LATENCY - 1);
        end
      end
    end

    if (LATENCY >= 2) begin : g_chk
      AST_BUSY_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (new_res ##1 (req_valid && bank_sel == $past(bank_sel)
                      && req_index != $past(req_index))) |-> !grant); // R3
      AST_REPEAT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (new_res ##1 (req_valid && req_index == $past(req_index)
                      && cyc == $past(cyc))) |-> grant); // R4
    end
  end

endmodule

// File: tb/test_banked_access_gate.sv
`timescale 1ns/1ps
module test_banked_access_gate;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [7:0] req_index = '0;
  logic g0, d0, g1, d1, g2, d2;

  always #5 clk = ~clk;

  banked_access_gate #(.NUM_BANKS(4), .IDX_W(8), .LATENCY(3), .CLK_PER_CYC(2), .CYC_W(24))
    i_banked_access_gate (.clk(clk), .rst_n(rst_n), .req_valid(req_valid),
                          .req_index(req_index), .grant(g0), .deny(d0));
  banked_access_gate #(.NUM_BANKS(1), .IDX_W(8), .LATENCY(2), .CLK_PER_CYC(1), .CYC_W(24))
    i_single (.clk(clk), .rst_n(rst_n), .req_valid(req_valid),
              .req_index(req_index), .grant(g1), .deny(d1));
  banked_access_gate #(.NUM_BANKS(1), .IDX_W(8), .LATENCY(0), .CLK_PER_CYC(1), .CYC_W(24))
    i_zero (.clk(clk), .rst_n(rst_n), .req_valid(req_valid),
            .req_index(req_index), .grant(g2), .deny(d2));

  int checks = 0;
  int fails = 0;
  int k = 0;
  int nb [3] = '{4, 1, 1};
  int lt [3] = '{3, 2, 0};
  int dv [3] = '{2, 1, 1};
  int mi [3][8];
  int ms [3][8];
  int me [3][8];

  function automatic bit model_grant(int u, int idx, int t, output bit nw);
    int b;
    nw = 1'b0;
    if (lt[u] == 0) return 1'b1;
    b = idx % nb[u];
    if (me[u][b] >= t) return (ms[u][b] == t) && (mi[u][b] == idx);
    nw = 1'b1;
    return 1'b1;
  endfunction

  task automatic check(string tag, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b (k=%0d idx=%0d)", tag, what, act, exp, k, req_index);
    end
  endtask

  task automatic step(bit vld, int idx, string tag);
    @(negedge clk);
    req_valid = vld;
    req_index = 8'(idx);
    #1;
    for (int u = 0; u < 3; u++) begin
      bit nw, eg, ag, ad;
      string lb;
      int t;
      t  = 1 + k / dv[u];
      eg = vld ? model_grant(u, idx, t, nw) : 1'b0;
      if (!vld) nw = 1'b0;
      ag = (u == 0) ? g0 : (u == 1) ? g1 : g2;
      ad = (u == 0) ? d0 : (u == 1) ? d1 : d2;
      if (u == 0 && tag != "") lb = tag;
      else if (u == 2) lb = "R1";
      else if (!vld) lb = "R9";
      else if (u == 1) lb = "R7";
      else if (!eg) lb = "R3";
      else if (!nw) lb = "R4";
      else lb = "R5";
      check(lb, $sformatf("unit%0d grant", u), ag, eg);
      check("R9", $sformatf("unit%0d deny", u), ad, vld && !eg);
      if (nw) begin
        int b;
        b = idx % nb[u];
        mi[u][b] = idx;
        ms[u][b] = t;
        me[u][b] = t + lt[u] - 1;
      end
    end
    @(posedge clk);
    k++;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int last;
    void'($urandom(32'd20240611));
    for (int u = 0; u < 3; u++)
      for (int b = 0; b < 8; b++) begin
        mi[u][b] = 0; ms[u][b] = 0; me[u][b] = 0;
      end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    step(1, 5,  "R8");  // first request after reset
    step(1, 5,  "R4");  // same index, same access cycle
    step(1, 9,  "R3");  // bank 1 held by index 5
    step(1, 6,  "R6");  // bank 2 independent
    step(1, 13, "R2");  // 13 mod 4 = 1, still held
    step(1, 5,  "R4");  // same index, later cycle: denied
    step(1, 13, "R5");  // reservation expired
    step(0, 13, "R9");
    last = 0;
    for (int n = 0; n < 4000; n++) begin
      int idx;
      bit v;
      v = ($urandom_range(0, 3) != 0);
      idx = ($urandom_range(0, 3) == 0) ? last : int'($urandom_range(0, 15));
      if ($urandom_range(0, 9) == 0) idx = int'($urandom_range(0, 255));
      step(v, idx, "");
      last = idx;
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule